// File: doc/BRIEF.md
# Low-Power Mode Entry Controller

This block puts a small microcontroller into a retention stop or into one of four deep stop levels. Software programs it through four byte-wide registers: an allow mask, a mode request, a deep-level select and a read-only one-hot status. A request is honoured only when its allow bit is set. An honoured request stops the core clock at once and raises a stop request to the peripherals. The system and bus clocks stop only after every peripheral has acknowledged.

Once the clocks are stopped, the status register names the mode that was entered. A set of power and retention outputs then follows that mode: logic supply, reduced logic voltage, two RAM partitions, the flash-backed auxiliary RAM, the always-on register file, I/O hold, the low-power oscillator and the power-on-reset circuit. The controller aborts the entry if the acknowledges do not all arrive within a programmable window. Leaving a stop mode is outside this block and is done through reset.

Top module: `lpm_ctrl`

## Requirements
- R1: After reset, offsets 0, 1, 2 and 3 read 0x00, 0x00, 0x03 and 0x01. All three clock enables are high and stop_req is low.
- R2: Register fields, with all other bits reserved:
  - Offset 0 is the allow mask: bit0 allows retention stop and bit1 allows deep stop.
  - Offset 1 is the request register: bits[1:0] select the target (0 run, 1 retention stop, 2 deep stop, 3 no request) and bits[7:4] hold the timeout code.
  - Offset 2 selects the deep level in bits[1:0] and holds the reset-keep bit in bit2.
  - Reserved bits read 0 and have no effect. Writes to offset 3 are ignored.
- R3: A request whose allow bit is clear leaves every clock enabled, stop_req low and status at 0x01.
- R4: An accepted request drops core_clk_en and raises stop_req at the edge of the write. The system and bus clock enables fall at the first edge at which all stop_ack bits are high, and not before.
- R5: Status is one-hot: bit0 run, bit1 retention stop, bit2 deep 3, bit3 deep 2, bit4 deep 1, bit5 deep 0. It changes at the same edge as the system clock stop.
- R6: In retention stop, logic stays powered with logic_lowv high. Both RAM partitions, the auxiliary RAM, the oscillator and the reset circuit stay on, and I/O is not held.
- R7: In every deep level, logic and the auxiliary RAM are off and I/O is held. Deep 3 keeps both RAM partitions on.
- R8: Deep 2 keeps RAM partition 0 (ram_pwr[0]) on and turns partition 1 (ram_pwr[1]) off.
- R9: Deep 1 and deep 0 turn both RAM partitions off. regfile_pwr is high in every mode.
- R10: Deep 0 turns lpo_en off, and por_en then equals the reset-keep bit. por_en is high in every other mode.
- R11: If the acknowledges are still incomplete after (code+1)*TO_STEP cycles of waiting, the entry aborts. core_clk_en returns high, stop_req falls and status stays 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| stop_ack | input | N_PERIPH | Peripheral stop acknowledges |
| stop_req | output | 1 | Stop request to peripherals |
| core_clk_en | output | 1 | Core clock enable |
| sys_clk_en | output | 1 | System clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| logic_pwr | output | 1 | Internal logic supply on |
| logic_lowv | output | 1 | Logic supply reduced |
| ram_pwr | output | 2 | RAM partition power, bit0 = partition 0 |
| aux_ram_pwr | output | 1 | Auxiliary RAM power |
| regfile_pwr | output | 1 | Always-on register file power |
| io_hold | output | 1 | Hold I/O states |
| lpo_en | output | 1 | Low-power oscillator enable |
| por_en | output | 1 | Power-on-reset circuit enable |

## Verification
The hardest case to reach is the abort path. The acknowledges must stay partly incomplete for exactly the programmed window and then be checked on both sides of the abort edge. The bench holds one acknowledge low at two timeout codes and expects the stopped core clock on the last cycle of the window and a restored clock on the next. A second case raises the acknowledges one by one inside the window, to show that a partial set never stops the system clock.

// File: rtl/lpm_pkg.sv
// Package: shared constants for the low-power mode entry controller.
// Assumes the byte offsets and one-hot status positions below are fixed.
package lpm_pkg;

    typedef enum logic [1:0] {
        SEQ_RUN  = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_STOP = 2'd2
    } seq_state_e;

    localparam logic [1:0] ADDR_ALLOW = 2'd0;
    localparam logic [1:0] ADDR_REQ   = 2'd1;
    localparam logic [1:0] ADDR_DEEP  = 2'd2;
    localparam logic [1:0] ADDR_STAT  = 2'd3;

    localparam logic [1:0] TGT_RETAIN = 2'd1;
    localparam logic [1:0] TGT_DEEP   = 2'd2;

    localparam int N_RW  = 3;
    localparam int N_RAM = 2;

    // Reset values and writable masks, index = byte offset
    localparam logic [N_RW-1:0][7:0] RW_RESET = {8'h03, 8'h00, 8'h00};
    localparam logic [N_RW-1:0][7:0] RW_MASK  = {8'h07, 8'hF3, 8'h03};

    localparam logic [7:0] STAT_RUN    = 8'h01;
    localparam logic [7:0] STAT_RETAIN = 8'h02;
    localparam logic [7:0] STAT_DEEP3  = 8'h04;

endpackage

// File: rtl/lpm_regs.sv
// Module: register bank and request decoder.
// Holds the allow, request and deep-select registers, returns read data and
// turns an allowed request write in run state into a one-cycle request.
// Assumes single-cycle writes on the same clock.
module lpm_regs
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       in_run,
    input  logic [7:0] stat,
    output logic [7:0] rdata,
    output logic       req_valid,
    output logic [7:0] req_onehot,
    output logic [3:0] req_code,
    output logic       por_keep
);

    logic [N_RW-1:0][7:0] rw_q;
    logic [1:0]           tgt;
    logic                 wr_req;
    logic                 want_retain;
    logic                 want_deep;

    // Store masked write data; offset 3 has no storage here
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rw_q <= RW_RESET;
        end else begin
            for (int i = 0; i < N_RW; i++) begin
                if (wr && addr == 2'(i)) begin
                    rw_q[i] <= wdata & RW_MASK[i];
                end
            end
        end
    end

    // Read multiplexer; status comes from the sequencer
    always_comb begin
        case (addr)
            ADDR_ALLOW: rdata = rw_q[0];
            ADDR_REQ:   rdata = rw_q[1];
            ADDR_DEEP:  rdata = rw_q[2];
            default:    rdata = stat;
        endcase
    end

    // Decode an allowed request from the write in flight
    always_comb begin
        tgt         = wdata[1:0];
        wr_req      = wr && (addr == ADDR_REQ) && in_run;
        want_retain = wr_req && (tgt == TGT_RETAIN) && rw_q[0][0];
        want_deep   = wr_req && (tgt == TGT_DEEP) && rw_q[0][1];
        req_valid   = want_retain || want_deep;
        req_code    = wdata[7:4];
        if (want_deep) begin
            req_onehot = STAT_DEEP3 << (2'd3 - rw_q[2][1:0]);
        end else begin
            req_onehot = STAT_RETAIN;
        end
    end

    assign por_keep = rw_q[2][2];

endmodule

// File: rtl/lpm_seq.sv
// Module: clock shutdown sequencer.
// Stops the core clock on a request, waits for every stop acknowledge within
// a timeout window, then stops system and bus clocks and latches status.
// Assumes stop_ack is synchronous to clk.
module lpm_seq
    import lpm_pkg::*;
#(
    parameter int N_PERIPH = 4,
    parameter int TO_STEP  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [7:0]          req_onehot,
    input  logic [3:0]          req_code,
    input  logic [N_PERIPH-1:0] stop_ack,
    output logic                in_run,
    output logic                stop_req,
    output logic                core_clk_en,
    output logic                sys_clk_en,
    output logic                bus_clk_en,
    output logic [7:0]          stat
);

    localparam int TO_MAX = 16 * TO_STEP;
    localparam int CW     = $clog2(TO_MAX + 1);

    seq_state_e    state;
    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic [CW-1:0] limit_next;
    logic [7:0]    pend;
    logic          all_ack;

    // Window length for the request being accepted
    assign limit_next = CW'((32'(req_code) + 32'd1) * 32'(TO_STEP));
    assign all_ack    = &stop_ack;

    // Sequence state, timeout counter and status register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEQ_RUN;
            cnt   <= '0;
            limit <= '0;
            pend  <= STAT_RUN;
            stat  <= STAT_RUN;
        end else begin
            case (state)
                SEQ_RUN: begin
                    if (req_valid) begin
                        state <= SEQ_WAIT;
                        cnt   <= '0;
                        limit <= limit_next;
                        pend  <= req_onehot;
                    end
                end
                SEQ_WAIT: begin
                    if (all_ack) begin
                        state <= SEQ_STOP;
                        stat  <= pend;
                    end else if (cnt == limit - 1'b1) begin
                        state <= SEQ_RUN;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_STOP;
            endcase
        end
    end

    // Clock enables decoded from the sequence state
    always_comb begin
        in_run      = (state == SEQ_RUN);
        stop_req    = !in_run;
        core_clk_en = in_run;
        sys_clk_en  = (state != SEQ_STOP);
        bus_clk_en  = (state != SEQ_STOP);
    end

endmodule

// File: rtl/lpm_domains.sv
// Module: power-domain decoder.
// Maps the one-hot mode status to supply, retention and enable outputs.
// Assumes stat_lo is one-hot (bit0 run .. bit5 deepest level).
module lpm_domains
    import lpm_pkg::*;
(
    input  logic [5:0]       stat_lo,
    input  logic             por_keep,
    output logic             logic_pwr,
    output logic             logic_lowv,
    output logic [N_RAM-1:0] ram_pwr,
    output logic             aux_ram_pwr,
    output logic             regfile_pwr,
    output logic             io_hold,
    output logic             lpo_en,
    output logic             por_en
);

    logic       deep;
    logic [1:0] lvl;

    // Deep flag and deep level from the one-hot status
    always_comb begin
        deep = |stat_lo[5:2];
        if (stat_lo[2])      lvl = 2'd3;
        else if (stat_lo[3]) lvl = 2'd2;
        else if (stat_lo[4]) lvl = 2'd1;
        else                 lvl = 2'd0;
    end

    // Partition p stays powered down to deep level p+2
    for (genvar p = 0; p < N_RAM; p++) begin : g_ram
        assign ram_pwr[p] = !deep || (32'(lvl) >= p + 2);
    end

    // Remaining domain controls
    always_comb begin
        logic_pwr   = !deep;
        logic_lowv  = stat_lo[1];
        aux_ram_pwr = !deep;
        regfile_pwr = 1'b1;
        io_hold     = deep;
        lpo_en      = !stat_lo[5];
        por_en      = !stat_lo[5] || por_keep;
    end

endmodule

// File: rtl/lpm_ctrl.sv
// Module: top of the low-power mode entry controller.
// Connects the register bank, the shutdown sequencer and the domain decoder.
// Assumes a synchronous register bus and synchronous acknowledges.
module lpm_ctrl
    import lpm_pkg::*;
#(
    parameter int N_PERIPH = 4,
    parameter int TO_STEP  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic [7:0]          reg_wdata,
    output logic [7:0]          reg_rdata,
    input  logic [N_PERIPH-1:0] stop_ack,
    output logic                stop_req,
    output logic                core_clk_en,
    output logic                sys_clk_en,
    output logic                bus_clk_en,
    output logic                logic_pwr,
    output logic                logic_lowv,
    output logic [1:0]          ram_pwr,
    output logic                aux_ram_pwr,
    output logic                regfile_pwr,
    output logic                io_hold,
    output logic                lpo_en,
    output logic                por_en
);

    logic       in_run;
    logic [7:0] mode_stat;
    logic       req_valid;
    logic [7:0] req_onehot;
    logic [3:0] req_code;
    logic       por_keep;

    lpm_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr         (reg_wr),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .in_run     (in_run),
        .stat       (mode_stat),
        .rdata      (reg_rdata),
        .req_valid  (req_valid),
        .req_onehot (req_onehot),
        .req_code   (req_code),
        .por_keep   (por_keep)
    );

    lpm_seq #(
        .N_PERIPH (N_PERIPH),
        .TO_STEP  (TO_STEP)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_onehot  (req_onehot),
        .req_code    (req_code),
        .stop_ack    (stop_ack),
        .in_run      (in_run),
        .stop_req    (stop_req),
        .core_clk_en (core_clk_en),
        .sys_clk_en  (sys_clk_en),
        .bus_clk_en  (bus_clk_en),
        .stat        (mode_stat)
    );

    lpm_domains i_dom (
        .stat_lo     (mode_stat[5:0]),
        .por_keep    (por_keep),
        .logic_pwr   (logic_pwr),
        .logic_lowv  (logic_lowv),
        .ram_pwr     (ram_pwr),
        .aux_ram_pwr (aux_ram_pwr),
        .regfile_pwr (regfile_pwr),
        .io_hold     (io_hold),
        .lpo_en      (lpo_en),
        .por_en      (por_en)
    );

endmodule

// File: rtl/lpm_ctrl_chk.sv
// Module: property checker bound to lpm_ctrl.
// Watches the clock shutdown order, status encoding and domain outputs.
module lpm_ctrl_chk #(
    parameter int N_PERIPH = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N_PERIPH-1:0] stop_ack,
    input logic                stop_req,
    input logic                core_clk_en,
    input logic                sys_clk_en,
    input logic [7:0]          stat,
    input logic                logic_pwr,
    input logic                aux_ram_pwr,
    input logic [1:0]          ram_pwr,
    input logic                io_hold,
    input logic                lpo_en
);

    AST_CORE_BEFORE_SYS: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_clk_en |-> !core_clk_en); // R4
    AST_SYS_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_clk_en) |-> $past(&stop_ack)); // R4
    AST_STAT_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(stat) == 1); // R5
    AST_STAT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (stat != 8'h01) |-> !sys_clk_en); // R5
    AST_DEEP_LOGIC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (|stat[5:2]) |-> (!logic_pwr && !aux_ram_pwr && io_hold)); // R7
    AST_DEEP2_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        stat[3] |-> (ram_pwr == 2'b01)); // R8
    AST_DEEP0_LPO: assert property (@(posedge clk) disable iff (!rst_n)
        stat[5] |-> !lpo_en); // R10
    AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> (sys_clk_en && !stop_req && stat == 8'h01)); // R11

endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_PERIPH(N_PERIPH)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_ack    (stop_ack),
    .stop_req    (stop_req),
    .core_clk_en (core_clk_en),
    .sys_clk_en  (sys_clk_en),
    .stat        (mode_stat),
    .logic_pwr   (logic_pwr),
    .aux_ram_pwr (aux_ram_pwr),
    .ram_pwr     (ram_pwr),
    .io_hold     (io_hold),
    .lpo_en      (lpo_en)
);

// File: tb/test_lpm_ctrl.sv
// Scoreboard bench: stimulus tasks queue expected output vectors per cycle,
// a monitor pops and compares them a quarter period after each edge.
module test_lpm_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 4;
    localparam int STEP       = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [7:0]    reg_wdata = 8'h00;
    logic [7:0]    reg_rdata;
    logic [NP-1:0] stop_ack = '0;
    logic          stop_req, core_clk_en, sys_clk_en, bus_clk_en;
    logic          logic_pwr, logic_lowv, aux_ram_pwr, regfile_pwr;
    logic          io_hold, lpo_en, por_en;
    logic [1:0]    ram_pwr;

    lpm_ctrl #(.N_PERIPH(NP), .TO_STEP(STEP)) i_lpm_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stop_ack(stop_ack),
        .stop_req(stop_req), .core_clk_en(core_clk_en), .sys_clk_en(sys_clk_en),
        .bus_clk_en(bus_clk_en), .logic_pwr(logic_pwr), .logic_lowv(logic_lowv),
        .ram_pwr(ram_pwr), .aux_ram_pwr(aux_ram_pwr), .regfile_pwr(regfile_pwr),
        .io_hold(io_hold), .lpo_en(lpo_en), .por_en(por_en)
    );

    typedef struct {
        int          at;
        string       req;
        logic [12:0] val;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    wire [12:0] obs = {stop_req, core_clk_en, sys_clk_en, bus_clk_en,
                       logic_pwr, logic_lowv, ram_pwr[0], ram_pwr[1],
                       aux_ram_pwr, regfile_pwr, io_hold, lpo_en, por_en};

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Domain bits per mode: 0 run,1 retain,2 deep3,3 deep2,4 deep1,5 deep0
    function automatic logic [8:0] dom(int m, bit keep);
        case (m)
            0:       return 9'b1_0_1_1_1_1_0_1_1;
            1:       return 9'b1_1_1_1_1_1_0_1_1;
            2:       return 9'b0_0_1_1_0_1_1_1_1;
            3:       return 9'b0_0_1_0_0_1_1_1_1;
            4:       return 9'b0_0_0_0_0_1_1_1_1;
            default: return {8'b0_0_0_0_0_1_1_0, keep};
        endcase
    endfunction

    // phase 0 running, 1 waiting for acks, 2 clocks stopped
    function automatic logic [12:0] vec(int phase, int m, bit keep);
        logic [3:0] c;
        case (phase)
            0:       c = 4'b0111;
            1:       c = 4'b1011;
            default: c = 4'b1000;
        endcase
        return {c, dom(m, keep)};
    endfunction

    task automatic push(int at, string r, logic [12:0] v);
        item_t it;
        it.at = at; it.req = r; it.val = v;
        sb.push_back(it);
    endtask

    // Monitor: compare queued expectations in their cycle
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD / 4);
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                item_t it;
                it = sb.pop_front();
                checks++;
                if (it.at != cyc || obs !== it.val) begin
                    errors++;
                    $display("FAIL %s cycle %0d (due %0d): actual %b expected %b",
                             it.req, cyc, it.at, obs, it.val);
                end
            end
        end
    end

    task automatic drain();
        while (sb.size() > 0) @(negedge clk);
    endtask

    task automatic reg_write(logic [1:0] a, logic [7:0] d, output int e0);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        e0 = cyc;
    endtask

    task automatic reg_read(logic [1:0] a, logic [7:0] exp, string r);
        @(negedge clk);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s read offset %0d: actual %h expected %h", r, a, reg_rdata, exp);
        end
    endtask

    task automatic reset_dut();
        drain();
        @(negedge clk);
        rst_n = 1'b0; stop_ack = '0; reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic deep_case(int lvl, bit keep, int m, string r);
        int e;
        reset_dut();
        reg_write(2'd0, 8'h02, e);
        reg_write(2'd2, 8'(lvl) | (8'(keep) << 2), e);
        stop_ack = '1;
        reg_write(2'd1, 8'h02, e);
        push(e + 1, r, vec(2, m, keep));
        push(e + 3, r, vec(2, m, keep));
        drain();
        reg_read(2'd3, 8'h01 << m, "R5");
    endtask

    initial begin
        int e;
        // R1: reset state
        reset_dut();
        push(cyc + 1, "R1", vec(0, 0, 1'b1));
        reg_read(2'd0, 8'h00, "R1");
        reg_read(2'd1, 8'h00, "R1");
        reg_read(2'd2, 8'h03, "R1");
        reg_read(2'd3, 8'h01, "R1");
        drain();

        // R2: reserved bits masked, status write ignored, target 3 no request
        reg_write(2'd0, 8'hFF, e);
        reg_read(2'd0, 8'h03, "R2");
        reg_write(2'd3, 8'h00, e);
        reg_read(2'd3, 8'h01, "R2");
        reg_write(2'd2, 8'hFF, e);
        reg_read(2'd2, 8'h07, "R2");
        stop_ack = '1;
        reg_write(2'd1, 8'h0F, e);
        push(e + 1, "R2", vec(0, 0, 1'b1));
        push(e + 2, "R2", vec(0, 0, 1'b1));
        drain();
        reg_read(2'd1, 8'h03, "R2");

        // R3: disallowed requests
        reset_dut();
        stop_ack = '1;
        reg_write(2'd0, 8'h01, e);
        reg_write(2'd1, 8'h02, e);
        push(e + 1, "R3", vec(0, 0, 1'b1));
        push(e + 2, "R3", vec(0, 0, 1'b1));
        drain();
        reg_write(2'd0, 8'h02, e);
        reg_write(2'd1, 8'h01, e);
        push(e + 1, "R3", vec(0, 0, 1'b1));
        drain();
        reg_read(2'd3, 8'h01, "R3");

        // R4 R5 R6: retention stop with acks arriving one at a time
        reset_dut();
        reg_write(2'd0, 8'h03, e);
        reg_write(2'd1, 8'hF1, e);
        stop_ack = 4'b0011;
        push(e + 1, "R4", vec(1, 0, 1'b1));
        push(e + 2, "R4", vec(1, 0, 1'b1));
        push(e + 3, "R4", vec(1, 0, 1'b1));
        push(e + 4, "R4", vec(2, 1, 1'b1));
        push(e + 5, "R6", vec(2, 1, 1'b1));
        @(negedge clk);
        stop_ack = 4'b0111;
        repeat (2) @(negedge clk);
        stop_ack = 4'b1111;
        drain();
        reg_read(2'd3, 8'h02, "R5");

        // R7..R10: deep levels
        deep_case(3, 1'b0, 2, "R7");
        deep_case(2, 1'b0, 3, "R8");
        deep_case(1, 1'b0, 4, "R9");
        deep_case(0, 1'b0, 5, "R10");
        deep_case(0, 1'b1, 5, "R10");

        // R11: timeout abort at two window lengths
        reset_dut();
        reg_write(2'd0, 8'h01, e);
        reg_write(2'd1, 8'h01, e);
        push(e + 3, "R11", vec(1, 0, 1'b1));
        push(e + 4, "R11", vec(0, 0, 1'b1));
        drain();
        reg_read(2'd3, 8'h01, "R11");
        stop_ack = 4'b0111;
        reg_write(2'd1, 8'h11, e);
        push(e + 7, "R11", vec(1, 0, 1'b1));
        push(e + 8, "R11", vec(0, 0, 1'b1));
        drain();
        reg_read(2'd3, 8'h01, "R11");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule